// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount held in a general register, and produces both the shifted value and the updated carry flag. Four operations are supported: logical left, logical right, arithmetic right and rotate right. Only the least significant byte of the amount register is taken into account, so any amount from 0 to 255 can occur. Each amount class has its own carry rule: zero, 1 to width−1, exactly the width, and above the width.

The data path is a logarithmic barrel network for each of the four operations, driven by the amount modulo the width. A separate decoder classifies the full byte, and a carry selector picks the flag bit. A final multiplexer applies the out-of-range results. The result and carry are registered, so they appear one clock after the inputs are presented. A synchronous active-high reset clears both.

Top module: `shf_reg_shifter`

## Requirements
- R1: Only bits 7:0 of the 32-bit amount input affect the outputs; bits 31:8 are ignored.
- R2: With an amount byte of 0, the result equals the operand and the carry out equals the carry in, for every shift type.
- R3: Logical left by n in 1..31 yields operand shifted left with zero fill, and the carry equals operand bit 32−n.
- R4: Logical left by exactly 32 yields 0 with carry equal to operand bit 0; by 33..255 it yields 0 with carry 0.
- R5: Logical right by n in 1..31 yields operand shifted right with zero fill, and the carry equals operand bit n−1.
- R6: Logical right by exactly 32 yields 0 with carry equal to operand bit 31; by 33..255 it yields 0 with carry 0.
- R7: Arithmetic right by n in 1..31 fills with operand bit 31 and sets carry to operand bit n−1. By 32..255 every result bit equals operand bit 31, and so does the carry.
- R8: Rotate right uses the amount modulo 32. When the amount is a non-zero multiple of 32, the result equals the operand and the carry equals operand bit 31.
- R9: Rotate right by an amount whose value modulo 32 is m in 1..31 yields the operand rotated right by m, with carry equal to operand bit m−1.
- R10: The shift-type input selects 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R11: The outputs are registered: the result and carry for inputs present at a rising clock edge appear after that edge. A synchronous reset held high at an edge clears the result to 0 and the carry to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Value to shift |
| amt_reg_i | input | 32 | Register holding the shift amount; only the low byte is used |
| kind_i | input | 2 | Shift type (see R10) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Registered shift result |
| carry_o | output | 1 | Registered carry flag |

## Verification
Both outputs are due exactly one rising edge after their inputs. The bench therefore drives a new operand, amount, type and carry on a falling edge. It compares the outputs on the next falling edge against a behavioural model that works on a 64-bit widened operand, so each comparison covers precisely one clock. All 256 amount bytes are swept for every type, with several operands and random upper amount bits. Directed cases cover the reset value and how the type encodings differ on a negative operand.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;

  // Classification of the full amount byte
  typedef struct packed {
    logic is_zero;     // byte == 0
    logic at_width;    // byte == WIDTH
    logic over_width;  // byte >  WIDTH
    logic low_zero;    // byte mod WIDTH == 0
  } amt_class_t;

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic [SH_W-1:0]  low_o,
  output amt_class_t       cls_o
);

  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(WIDTH);

  always_comb begin
    low_o            = amt_i[SH_W-1:0];
    cls_o.is_zero    = (amt_i == '0);
    cls_o.at_width   = (amt_i == WIDTH_AMT);
    cls_o.over_width = (amt_i > WIDTH_AMT);
    cls_o.low_zero   = (amt_i[SH_W-1:0] == '0);
  end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int WIDTH = 32,
  parameter int MODE  = 0,   // 0 left, 1 right logical, 2 right arithmetic, 3 rotate
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SH_W-1:0]  amt_i,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] stg [0:SH_W];
  assign stg[0] = data_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [WIDTH-1:0] moved;
    if (MODE == 0) begin : g_lsl
      assign moved = {stg[k][WIDTH-1-D:0], {D{1'b0}}};
    end else if (MODE == 1) begin : g_lsr
      assign moved = {{D{1'b0}}, stg[k][WIDTH-1:D]};
    end else if (MODE == 2) begin : g_asr
      assign moved = {{D{stg[k][WIDTH-1]}}, stg[k][WIDTH-1:D]};
    end else begin : g_ror
      assign moved = {stg[k][D-1:0], stg[k][WIDTH-1:D]};
    end
    assign stg[k+1] = amt_i[k] ? moved : stg[k];
  end

  assign data_o = stg[SH_W];

endmodule

// File: rtl/shf_carry_select.sv
module shf_carry_select
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [SH_W-1:0]  low_i,
  input  amt_class_t       cls_i,
  input  shift_kind_e      kind_i,
  input  logic             carry_i,
  output logic             carry_o
);

  logic [SH_W-1:0] idx_left;   // WIDTH - low, valid when low != 0
  logic [SH_W-1:0] idx_right;  // low - 1, valid when low != 0

  assign idx_left  = SH_W'('0) - low_i;
  assign idx_right = low_i - SH_W'(1);

  always_comb begin
    carry_o = carry_i;
    if (!cls_i.is_zero) begin
      unique case (kind_i)
        SHK_LSL: begin
          if (cls_i.over_width)    carry_o = 1'b0;
          else if (cls_i.at_width) carry_o = operand_i[0];
          else                     carry_o = operand_i[idx_left];
        end
        SHK_LSR: begin
          if (cls_i.over_width)    carry_o = 1'b0;
          else if (cls_i.at_width) carry_o = operand_i[WIDTH-1];
          else                     carry_o = operand_i[idx_right];
        end
        SHK_ASR: begin
          if (cls_i.over_width || cls_i.at_width) carry_o = operand_i[WIDTH-1];
          else                                    carry_o = operand_i[idx_right];
        end
        default: begin
          if (cls_i.low_zero) carry_o = operand_i[WIDTH-1];
          else                carry_o = operand_i[idx_right];
        end
      endcase
    end
  end

endmodule

// File: rtl/shf_reg_shifter.sv
module shf_reg_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [REG_W-1:0] amt_reg_i,
  input  logic [1:0]       kind_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);

  logic [AMT_W-1:0] amt_byte;
  logic             unused_amt_hi;
  assign amt_byte      = amt_reg_i[AMT_W-1:0];
  assign unused_amt_hi = ^amt_reg_i[REG_W-1:AMT_W];

  shift_kind_e kind;
  assign kind = shift_kind_e'(kind_i);

  logic [SH_W-1:0] low;
  amt_class_t      cls;

  shf_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .amt_i (amt_byte),
    .low_o (low),
    .cls_o (cls)
  );

  logic [WIDTH-1:0] shifted [0:3];
  for (genvar m = 0; m < 4; m++) begin : g_path
    shf_barrel #(.WIDTH(WIDTH), .MODE(m)) u_barrel (
      .data_i (operand_i),
      .amt_i  (low),
      .data_o (shifted[m])
    );
  end

  logic carry_nxt;
  shf_carry_select #(.WIDTH(WIDTH)) u_carry (
    .operand_i (operand_i),
    .low_i     (low),
    .cls_i     (cls),
    .kind_i    (kind),
    .carry_i   (carry_i),
    .carry_o   (carry_nxt)
  );

  logic big;
  logic [WIDTH-1:0] result_nxt;
  assign big = cls.at_width | cls.over_width;

  always_comb begin
    result_nxt = operand_i;
    if (!cls.is_zero) begin
      unique case (kind)
        SHK_LSL: result_nxt = big ? '0 : shifted[0];
        SHK_LSR: result_nxt = big ? '0 : shifted[1];
        SHK_ASR: result_nxt = big ? {WIDTH{operand_i[WIDTH-1]}} : shifted[2];
        default: result_nxt = shifted[3];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      result_o <= result_nxt;
      carry_o  <= carry_nxt;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result_o == '0 && carry_o == 1'b0)); // R11

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (amt_reg_i[AMT_W-1:0] == '0) |=>
      (result_o == $past(operand_i) && carry_o == $past(carry_i))); // R2

  AST_LSL_OVER: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'b00 && amt_reg_i[AMT_W-1:0] > AMT_W'(WIDTH)) |=>
      (result_o == '0 && carry_o == 1'b0)); // R4

  AST_LSR_AT_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'b01 && amt_reg_i[AMT_W-1:0] == AMT_W'(WIDTH)) |=>
      (result_o == '0 && carry_o == $past(operand_i[WIDTH-1]))); // R6

  AST_ASR_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'b10 && amt_reg_i[AMT_W-1:0] >= AMT_W'(WIDTH)) |=>
      ($countones(result_o) == ($past(operand_i[WIDTH-1]) ? WIDTH : 0) &&
       carry_o == $past(operand_i[WIDTH-1]))); // R7

  AST_ROR_MULTIPLE: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'b11 && amt_reg_i[AMT_W-1:0] != '0 && amt_reg_i[SH_W-1:0] == '0) |=>
      (result_o == $past(operand_i) && carry_o == $past(operand_i[WIDTH-1]))); // R8

endmodule

// File: tb/shf_reg_shifter_bench.sv
module shf_reg_shifter_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic [1:0]  kind_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_reg_shifter u_shf_reg_shifter (
    .clk       (clk),
    .rst       (rst),
    .operand_i (operand_i),
    .amt_reg_i (amt_reg_i),
    .kind_i    (kind_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
  );

  // Behavioural model on a widened 64-bit value
  task automatic model(input logic [31:0] op, input logic [7:0] n, input logic [1:0] k,
                       input logic c, output logic [31:0] r, output logic cy);
    logic [63:0] t;
    int m;
    if (n == 0) begin
      r = op; cy = c;
    end else begin
      case (k)
        2'b00: begin t = {32'b0, op} << n; r = t[31:0]; cy = t[32]; end
        2'b01: begin t = {op, 32'b0} >> n; r = t[63:32]; cy = t[31]; end
        2'b10: begin t = 64'($signed({op, 32'b0}) >>> n); r = t[63:32]; cy = t[31]; end
        default: begin
          m = int'(n) % 32;
          if (m == 0) begin r = op; cy = op[31]; end
          else begin r = (op >> m) | (op << (32 - m)); cy = op[m-1]; end
        end
      endcase
    end
  endtask

  function automatic string tag_for(input logic [1:0] k, input int n);
    if (n == 0) return "R2";
    case (k)
      2'b00: return (n < 32) ? "R3" : "R4";
      2'b01: return (n < 32) ? "R5" : "R6";
      2'b10: return "R7";
      default: return (n % 32 == 0) ? "R8" : "R9";
    endcase
  endfunction

  task automatic run_one(input logic [31:0] op, input logic [31:0] areg, input logic [1:0] k,
                         input logic c, input string tag);
    logic [31:0] er;
    logic        ec;
    model(op, areg[7:0], k, c, er, ec);
    @(negedge clk);
    operand_i = op; amt_reg_i = areg; kind_i = k; carry_i = c;
    @(negedge clk);
    n_cmp++;
    if (result_o !== er || carry_o !== ec) begin
      n_bad++;
      $display("FAIL %s op=%h amt=%h kind=%0d cin=%0b : got %h/%0b expected %h/%0b",
               tag, op, areg, k, c, result_o, carry_o, er, ec);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] ops [0:3];
    ops[0] = 32'h8000_0001;
    ops[1] = 32'h7FFF_FFFE;
    ops[2] = $urandom();
    ops[3] = $urandom() | 32'h8000_0000;

    // R11: reset clears outputs, even with live inputs
    operand_i = 32'hDEAD_BEEF; amt_reg_i = 32'h0; carry_i = 1'b1;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got %h/%0b expected 00000000/0", result_o, carry_o);
    end
    @(negedge clk); rst = 1'b0;

    // Full sweep of the amount byte for each type (R10 encodings)
    for (int k = 0; k < 4; k++) begin
      for (int oi = 0; oi < 4; oi++) begin
        for (int n = 0; n < 256; n++) begin
          run_one(ops[oi], {$urandom() & 32'hFFFF_FF00} | 32'(n), 2'(k),
                  1'($urandom()), tag_for(2'(k), n));
        end
      end
    end

    // R1: upper amount bits set, low byte zero / 4
    run_one(32'h1234_5678, 32'hFFFF_FF00, 2'b00, 1'b1, "R1");
    run_one(32'h1234_5678, 32'hABCD_0004, 2'b01, 1'b0, "R1");
    run_one(32'h1234_5678, 32'h0000_0100, 2'b11, 1'b0, "R1");

    // R10: the four encodings on a negative operand, amount 4
    run_one(32'hF000_000F, 32'd4, 2'b00, 1'b0, "R10");
    run_one(32'hF000_000F, 32'd4, 2'b01, 1'b0, "R10");
    run_one(32'hF000_000F, 32'd4, 2'b10, 1'b0, "R10");
    run_one(32'hF000_000F, 32'd4, 2'b11, 1'b0, "R10");

    // R11: back-to-back inputs each appear after exactly one edge
    run_one(32'h0000_0003, 32'd1, 2'b00, 1'b0, "R11");
    run_one(32'h0000_0003, 32'd33, 2'b00, 1'b1, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule